// File: doc/BRIEF.md
# Balanced-Bitwidth Dot Product Engine

This block multiplies a vector of eight unsigned 8-bit activations by eight stored signed 8-bit weights and returns the exact sum of the products. It does not step through all eight activation bits of every element in turn. Instead it measures how many significant bits each activation carries. It then packs only those bit slots into a short schedule of cycles. In each cycle, eight single-bit multiply lanes each take one activation bit together with the matching weight, which is shifted left by a small amount. A narrow activation therefore gives its unused lanes to wider ones, and the run length follows the total number of significant bits instead of the widest element.

Weights are written one at a time through a small load port while the engine is idle. Vectors arrive on a valid/ready handshake. After acceptance the engine is busy until it has shown the 19-bit signed result for one cycle on its output strobe. Each schedule cycle has a base bit position. Every lane's shift is its bit position minus that base, and may be 0 to 3. The cycle's lane sum is added into the accumulator after a left shift by the base.

Top module: `ebb_dot`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_result is 0, and all eight weights read as zero, so a vector sent before any weight write returns 0.
- R2: The effective width of an activation is the index of its highest set bit plus one, and 0 for a zero value. A vector whose only nonzero element has width e takes exactly ceil(e/4) schedule cycles, because one cycle holds at most four bit positions of an element.
- R3: out_result is the two's-complement 19-bit value of the sum over i of x[i]*w[i]. x[i] is the unsigned byte in_vec[8*i+7:8*i] and w[i] is the signed byte last written to address i.
- R4: For a vector whose effective widths sum to T > 0 and whose widest element has width M, the number of schedule cycles L satisfies ceil(T/8) <= L <= M, and L never exceeds 8.
- R5: When all eight activations have the same effective width e > 0, the run takes exactly e cycles.
- R6: An all-zero vector produces result 0 with a latency of one cycle.
- R7: A vector is taken on a clock edge where in_valid and in_ready are both 1. From the next cycle, in_ready stays 0 until the cycle after the one-cycle out_valid pulse. in_valid asserted while in_ready is 0 is ignored. out_valid rises L cycles after the accepting edge (1 cycle for L = 0).
- R8: A weight write (wt_we = 1, address wt_addr) takes effect only on an edge where in_ready is 1. A write presented while busy is discarded.
- R9: A weight write on the same edge that accepts a vector is used by that vector.
- R10: out_result holds its value in every cycle except the one where out_valid rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Activation vector present |
| in_ready | output | 1 | Engine idle; vector and weight writes accepted |
| in_vec | input | 64 | Eight unsigned bytes, element i in bits 8*i+7:8*i |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | 3 | Weight index to write |
| wt_data | input | 8 | Signed weight value |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 19 | Signed dot product |

## Verification
Two things can happen on the same clock edge: a weight write and the acceptance of a vector. The bench presents a write to element 2 together with a vector that uses only element 2. The result must reflect the new weight. The bench also issues a weight write and a held in_valid while a long schedule is running. The result of that run must use the old weight, the extra vector must not start a second run, and a follow-up single-element vector must show that the busy write never landed. Random vectors with mixed element widths are compared with a bench-computed dot product, and their latencies are compared with the bounds derived from the effective widths.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

    localparam int N_ELEM = 8;
    localparam int XW     = 8;
    localparam int WW     = 8;
    localparam int WIN    = 4;

    localparam int EBW    = $clog2(XW + 1);
    localparam int XBW    = $clog2(XW);
    localparam int SHW    = $clog2(WIN);
    localparam int ELW    = $clog2(N_ELEM);
    localparam int LANEW  = WW + WIN - 1;
    localparam int SUMW   = LANEW + ELW;
    localparam int ACCW   = XW + WW + ELW;
    localparam int NCAND  = N_ELEM * WIN;

    typedef struct packed {
        logic           vld;
        logic [ELW-1:0] elem;
        logic [SHW-1:0] sh;
    } lane_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_t;

    // Index of the highest set bit plus one; zero for a zero value.
    function automatic logic [EBW-1:0] eff_width(input logic [XW-1:0] v);
        logic [EBW-1:0] r;
        r = '0;
        for (int p = 0; p < XW; p++) begin
            if (v[p]) r = EBW'(p + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/ebb_detect.sv
module ebb_detect
    import ebb_pkg::*;
(
    input  logic [N_ELEM-1:0][XW-1:0]  x,
    output logic [N_ELEM-1:0][EBW-1:0] eb
);

    for (genvar i = 0; i < N_ELEM; i++) begin : g_det
        assign eb[i] = eff_width(x[i]);
    end

endmodule

// File: rtl/ebb_equalizer.sv
module ebb_equalizer
    import ebb_pkg::*;
(
    input  logic [N_ELEM-1:0][EBW-1:0] eb,
    input  logic [N_ELEM-1:0][EBW-1:0] nxt,
    output logic [EBW-1:0]             base,
    output lane_cfg_t [N_ELEM-1:0]     lanes,
    output logic [N_ELEM-1:0][SHW:0]   take
);

    localparam int POSW = EBW + 1;

    logic [NCAND-1:0] cand;

    // Base of this cycle: lowest still-unscheduled bit position of any element.
    always_comb begin
        base = EBW'(XW);
        for (int i = 0; i < N_ELEM; i++) begin
            if ((nxt[i] < eb[i]) && (nxt[i] < base)) base = nxt[i];
        end
    end

    // Candidate slots, ordered by offset from base first, then element index.
    for (genvar k = 0; k < WIN; k++) begin : g_off
        for (genvar i = 0; i < N_ELEM; i++) begin : g_el
            logic [POSW-1:0] pos;
            assign pos = POSW'(base) + POSW'(k);
            assign cand[k*N_ELEM + i] = (POSW'(nxt[i]) <= pos) && (pos < POSW'(eb[i]));
        end
    end

    // Feeder: the first N_ELEM candidates in priority order fill the lanes.
    always_comb begin
        int used;
        used  = 0;
        lanes = '0;
        take  = '0;
        for (int j = 0; j < NCAND; j++) begin
            if (cand[j] && (used < N_ELEM)) begin
                lanes[used].vld  = 1'b1;
                lanes[used].elem = ELW'(j % N_ELEM);
                lanes[used].sh   = SHW'(j / N_ELEM);
                take[j % N_ELEM] = take[j % N_ELEM] + (SHW+1)'(1);
                used++;
            end
        end
    end

endmodule

// File: rtl/ebb_lane_tree.sv
module ebb_lane_tree
    import ebb_pkg::*;
(
    input  logic [N_ELEM-1:0][XW-1:0] x,
    input  logic [N_ELEM-1:0][WW-1:0] w,
    input  logic [EBW-1:0]            base,
    input  lane_cfg_t [N_ELEM-1:0]    lanes,
    output logic [SUMW-1:0]           sum
);

    logic [N_ELEM-1:0][LANEW-1:0] prod;

    for (genvar l = 0; l < N_ELEM; l++) begin : g_lane
        logic [EBW-1:0]   pos;
        logic             xbit;
        logic [WW-1:0]    wsel;
        logic [LANEW-1:0] wext;
        assign pos  = base + EBW'(lanes[l].sh);
        assign wsel = w[lanes[l].elem];
        assign xbit = lanes[l].vld && (pos < EBW'(XW)) && x[lanes[l].elem][pos[XBW-1:0]];
        assign wext = {{(LANEW-WW){wsel[WW-1]}}, wsel};
        assign prod[l] = xbit ? (wext << lanes[l].sh) : '0;
    end

    always_comb begin
        sum = '0;
        for (int l = 0; l < N_ELEM; l++) begin
            sum = sum + {{(SUMW-LANEW){prod[l][LANEW-1]}}, prod[l]};
        end
    end

endmodule

// File: rtl/ebb_dot.sv
module ebb_dot
    import ebb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [N_ELEM*XW-1:0]   in_vec,
    input  logic                   wt_we,
    input  logic [ELW-1:0]         wt_addr,
    input  logic [WW-1:0]          wt_data,
    output logic                   out_valid,
    output logic [ACCW-1:0]        out_result
);

    ctl_state_t                  st_q;
    logic [N_ELEM-1:0][XW-1:0]   x_q;
    logic [N_ELEM-1:0][WW-1:0]   w_q;
    logic [N_ELEM-1:0][EBW-1:0]  nxt_q;
    logic [ACCW-1:0]             acc_q;
    logic [ACCW-1:0]             res_q;

    logic [N_ELEM-1:0][EBW-1:0]  eb;
    logic [EBW-1:0]              base;
    lane_cfg_t [N_ELEM-1:0]      lanes;
    logic [N_ELEM-1:0][SHW:0]    take;
    logic [SUMW-1:0]             csum;
    logic [N_ELEM-1:0][EBW-1:0]  nxt_new;
    logic                        done_now;
    logic [ACCW-1:0]             acc_new;
    logic                        accept;

    ebb_detect u_det (
        .x  (x_q),
        .eb (eb)
    );

    ebb_equalizer u_eq (
        .eb    (eb),
        .nxt   (nxt_q),
        .base  (base),
        .lanes (lanes),
        .take  (take)
    );

    ebb_lane_tree u_tree (
        .x     (x_q),
        .w     (w_q),
        .base  (base),
        .lanes (lanes),
        .sum   (csum)
    );

    assign in_ready   = (st_q == ST_IDLE);
    assign out_valid  = (st_q == ST_DONE);
    assign out_result = res_q;
    assign accept     = in_valid && in_ready;

    always_comb begin
        done_now = 1'b1;
        for (int i = 0; i < N_ELEM; i++) begin
            nxt_new[i] = nxt_q[i] + EBW'(take[i]);
            if (nxt_new[i] < eb[i]) done_now = 1'b0;
        end
    end

    assign acc_new = acc_q + ({{(ACCW-SUMW){csum[SUMW-1]}}, csum} << base);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            x_q   <= '0;
            w_q   <= '0;
            nxt_q <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            if (wt_we && in_ready) w_q[wt_addr] <= wt_data;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        x_q   <= in_vec;
                        nxt_q <= '0;
                        acc_q <= '0;
                        st_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_new;
                    nxt_q <= nxt_new;
                    if (done_now) begin
                        res_q <= acc_new;
                        st_q  <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ebb_dot_chk.sv
module ebb_dot_chk
    import ebb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic [ACCW-1:0] out_result
);

    logic [3:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (in_valid && in_ready) begin
            run_cnt <= '0;
        end else if (!out_valid && !in_ready && (run_cnt != 4'hF)) begin
            run_cnt <= run_cnt + 4'd1;
        end
    end

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R7

    AST_BUSY_ON_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R7

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_result)); // R10

    AST_SCHED_LIMIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((run_cnt >= 4'd1) && (run_cnt <= 4'(N_ELEM)))); // R4

endmodule

bind ebb_dot ebb_dot_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/ebb_dot_tb.sv
module ebb_dot_tb;
    import ebb_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_vec = '0;
    logic         wt_we = 1'b0;
    logic [2:0]   wt_addr = '0;
    logic [7:0]   wt_data = '0;
    logic         out_valid;
    logic [18:0]  out_result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int w_model[8];

    always #5 clk = ~clk;

    ebb_dot u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_vec(in_vec), .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
        .out_valid(out_valid), .out_result(out_result)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL R7 watchdog act=%0d exp<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    function automatic int eb_of(input logic [7:0] v);
        int e = 0;
        for (int p = 0; p < 8; p++) if (v[p]) e = p + 1;
        return e;
    endfunction

    function automatic int ref_dot(input logic [63:0] xv);
        int s = 0;
        for (int i = 0; i < 8; i++) s += int'(xv[8*i +: 8]) * w_model[i];
        return s;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic load_w(input int a, input int v);
        @(negedge clk);
        wt_we = 1'b1; wt_addr = 3'(a); wt_data = 8'(v);
        @(negedge clk);
        wt_we = 1'b0;
        w_model[a] = v;
    endtask

    task automatic run_vec(input logic [63:0] xv, output int res, output int lat);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_vec = xv; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!out_valid && lat < 40);
        res = int'($signed(out_result));
    endtask

    // R3 value check plus R4 / R6 latency bounds
    task automatic judge(input logic [63:0] xv, output int lat);
        int res, t, m;
        run_vec(xv, res, lat);
        check("R3 dot product", res, ref_dot(xv));
        t = 0; m = 0;
        for (int i = 0; i < 8; i++) begin
            t += eb_of(xv[8*i +: 8]);
            if (eb_of(xv[8*i +: 8]) > m) m = eb_of(xv[8*i +: 8]);
        end
        if (t == 0) check("R6 zero-vector latency", lat, 1);
        else        check_rng("R4 schedule length", lat, (t + 7) / 8, (m < 8) ? m : 8);
    endtask

    initial begin
        int lat, res, n;
        logic [63:0] xv;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) w_model[i] = 0;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_result", int'(out_result), 0);
        rst = 1'b0;
        judge(64'h0102_0304_0506_0708, lat); // R1 weights cleared -> 0

        // Directed weights
        load_w(0, 3);   load_w(1, -2); load_w(2, 127); load_w(3, -128);
        load_w(4, 1);   load_w(5, 0);  load_w(6, -1);  load_w(7, 64);

        judge(64'h0, lat);                                   // R6
        judge({8{8'hFF}}, lat);
        check("R5 uniform width 8", lat, 8);
        judge({8{8'h0F}}, lat);
        check("R5 uniform width 4", lat, 4);
        judge({8{8'h01}}, lat);
        check("R5 uniform width 1", lat, 1);
        judge(64'h0000_0000_0000_00FF, lat);
        check("R2 single width 8", lat, 2);
        judge(64'h0000_0000_8000_0000, lat);
        check("R2 single msb element 3", lat, 2);
        judge(64'h0000_0500_0000_0000, lat);
        check("R2 single width 3", lat, 1);
        judge(64'h1F00_0000_0000_0000, lat);
        check("R2 single width 5", lat, 2);
        judge(64'h0101_0101_0101_01FF, lat);                 // R4 mixed
        judge(64'h80FF_0001_7F00_0203, lat);                 // R4 mixed

        // R9: weight write on the accepting edge
        judge(64'h0, lat);
        @(negedge clk);
        check("R9 idle before", int'(in_ready), 1);
        in_vec = 64'h0000_0000_0003_0000; in_valid = 1'b1;
        wt_we = 1'b1; wt_addr = 3'd2; wt_data = 8'd100;
        @(negedge clk);
        in_valid = 1'b0; wt_we = 1'b0; w_model[2] = 100;
        n = 0;
        while (!out_valid && n < 40) begin @(negedge clk); n++; end
        check("R9 coincident write used", int'($signed(out_result)), 300);

        // R7 / R8 / R10: activity while busy
        load_w(0, 5);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_vec = 64'h0000_0000_0000_00FF; in_valid = 1'b1;
        @(negedge clk);
        check("R7 ready low after accept", int'(in_ready), 0);
        in_vec = {8{8'hFF}};                      // held in_valid while busy
        wt_we = 1'b1; wt_addr = 3'd0; wt_data = 8'hF9;
        @(negedge clk);
        wt_we = 1'b0;
        n = 0;
        while (!out_valid && n < 40) begin @(negedge clk); n++; end
        check("R8 busy write discarded", int'($signed(out_result)), 1275);
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 pulse one cycle", int'(out_valid), 0);
        check("R10 result held", int'($signed(out_result)), 1275);
        @(negedge clk);
        check("R7 busy vector not started", int'(in_ready), 1);
        run_vec(64'h0000_0000_0000_0001, res, lat);
        check("R8 weight 0 unchanged", res, 5);

        // Random vectors with mixed widths
        for (int v = 0; v < 400; v++) begin
            if (v % 16 == 0) begin
                for (int i = 0; i < 8; i++) load_w(i, int'($signed(8'($urandom))));
            end
            if (v % 7 == 0) begin
                int e = int'($urandom % 9);
                for (int i = 0; i < 8; i++) begin
                    logic [7:0] b = 8'($urandom) & 8'((1 << e) - 1);
                    if (e > 0) b[e-1] = 1'b1;
                    xv[8*i +: 8] = b;
                end
                judge(xv, lat);
                if (e > 0) check("R5 random uniform width", lat, e);
            end else begin
                for (int i = 0; i < 8; i++)
                    xv[8*i +: 8] = 8'($urandom) & 8'((1 << ($urandom % 9)) - 1);
                judge(xv, lat);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule